// File: doc/BRIEF.md
# Programmable Multiplicity Logic Unit

This block watches 32 discrete logic inputs and turns coincidences among them into trigger outputs. Each input passes through a rising-edge detector and then through its own delay-and-gate generator. The delay and the gate width are counted in clock ticks (10 ns at the intended 100 MHz clock). The resulting gated levels feed two independent groups. Each group picks the inputs it cares about with a mask. It then drives three multiplicity outputs, each comparing the number of active masked inputs against its own threshold, and one pattern output that compares selected gated inputs with a programmed bit pattern.

Every input edge and every rising edge of a group output is counted in a saturating event counter. A selector port reads the counters out for debugging. All settings are written through a single-cycle register write port. A write to a dedicated address clears every counter.

Top module: `mlu_top`

## Requirements
- R1: After reset all outputs are low and all counters read zero. Every threshold resets to 63 and every mask, care mask, pattern, delay and width resets to zero.
- R2: Only a low-to-high transition of an input, as seen between two clock edges, starts its generator. An input held high starts nothing more, and an input already high during reset produces no edge.
- R3: A write to address i (0..31) sets input i's delay to wdata[7:0] and its width to wdata[15:8]. For an edge sampled at clock edge E0, the affected output is high after edges E(d+1) through E(d+w). A width of zero produces no gate.
- R4: A new edge on an input whose gate is already open restarts the gate at the full width, counted from the new edge.
- R5: Group g's input mask is written at address 64+4g. Gated inputs outside the mask have no effect on that group's outputs.
- R6: Group g's thresholds are written at address 67+4g, in the fields wdata[5:0], wdata[13:8] and wdata[21:16]. Multiplicity output maj_out[3g+k] is high, one cycle after the gated inputs, while the count of active masked gated inputs is greater than or equal to threshold k.
- R7: Group g's care mask is written at address 65+4g and its pattern at 66+4g. pat_out[g] is high while the care mask is nonzero and (masked gated inputs AND care) equals (pattern AND care).
- R8: Counter c (selected by cnt_sel) counts rising edges. Counters 0..31 count input edges, and counter 32+4g+k counts rises of group g's output k, where k=3 is the pattern output.
- R9: A counter at its maximum value stays there on further events.
- R10: A write to address 127 clears every counter to zero on the next clock edge, taking priority over a same-cycle event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick of delay or width per cycle |
| rst | input | 1 | Synchronous active-high reset |
| din | input | N_IN | Discrete logic inputs |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| cnt_sel | input | SEL_W | Counter select for readback |
| cnt_value | output | CNT_W | Selected counter value |
| maj_out | output | N_GRP*3 | Multiplicity outputs, group g output k at bit 3g+k |
| pat_out | output | N_GRP | Pattern outputs, one per group |

## Verification
The bound checker watches several invariants on every cycle. A group whose masked gated inputs are all idle keeps its nonzero-threshold outputs low. A group with an empty care mask never asserts its pattern output. A selected input counter moves only after an edge or a clear, a counter at full scale holds there, and a clear write leaves zero behind. The exact delay-to-gate cycle timing, the restart of an open gate, the thresholds at each multiplicity and the match or mismatch of particular patterns depend on programmed values and on stimulus history. Only the directed scenarios of the bench can show those.

// File: rtl/mlu_pkg.sv
package mlu_pkg;

    localparam int TICK_W      = 8;
    localparam int THR_W       = 6;
    localparam int N_THR       = 3;
    localparam int OUT_PER_GRP = N_THR + 1;
    localparam int ADDR_W      = 7;
    localparam int CFG_W       = 32;

    localparam logic [ADDR_W-1:0] GRP_BASE = 7'd64;
    localparam logic [ADDR_W-1:0] CLR_ADDR = 7'd127;

    // Per-input timing word: width in the upper byte, delay in the lower.
    typedef struct packed {
        logic [TICK_W-1:0] wid;
        logic [TICK_W-1:0] dly;
    } tcfg_t;

    typedef enum logic [1:0] {
        GR_MASK = 2'd0,
        GR_CARE = 2'd1,
        GR_PAT  = 2'd2,
        GR_THR  = 2'd3
    } grp_reg_e;

    function automatic logic [ADDR_W-1:0] grp_addr(input int g, input grp_reg_e r);
        return GRP_BASE + ADDR_W'(OUT_PER_GRP * g) + ADDR_W'(r);
    endfunction

endpackage

// File: rtl/mlu_ddg.sv
module mlu_ddg
    import mlu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  trig_i,
    input  tcfg_t cfg_i,
    output logic  gate_o
);

    logic [TICK_W-1:0] dly_cnt;
    logic [TICK_W-1:0] gate_cnt;
    logic              dly_done;

    assign dly_done = (dly_cnt == TICK_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_cnt  <= '0;
            gate_cnt <= '0;
        end else begin
            // Gate: load on an immediate edge or on delay expiry, else run down.
            if ((trig_i && cfg_i.dly == '0) || dly_done) begin
                gate_cnt <= cfg_i.wid;
            end else if (gate_cnt != '0) begin
                gate_cnt <= gate_cnt - TICK_W'(1);
            end
            // Delay: a new edge reloads it; otherwise count down to zero.
            if (trig_i && cfg_i.dly != '0) begin
                dly_cnt <= cfg_i.dly;
            end else if (dly_cnt != '0) begin
                dly_cnt <= dly_cnt - TICK_W'(1);
            end
        end
    end

    assign gate_o = (gate_cnt != '0);

endmodule

// File: rtl/mlu_group.sv
module mlu_group
    import mlu_pkg::*;
#(
    parameter int N_IN = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [N_IN-1:0]                  gate_i,
    input  logic [N_IN-1:0]                  mask_i,
    input  logic [N_IN-1:0]                  care_i,
    input  logic [N_IN-1:0]                  pat_i,
    input  logic [N_THR-1:0][THR_W-1:0]      thr_i,
    output logic [N_THR-1:0]                 maj_o,
    output logic                             pat_o
);

    localparam int HW = $clog2(N_IN + 1);

    logic [N_IN-1:0]  act;
    logic [HW-1:0]    hits;
    logic [N_THR-1:0] maj_n;
    logic             pat_n;

    always_comb begin
        act  = gate_i & mask_i;
        hits = '0;
        for (int i = 0; i < N_IN; i++) begin
            hits = hits + HW'(act[i]);
        end
    end

    for (genvar k = 0; k < N_THR; k++) begin : g_thr
        assign maj_n[k] = (32'(hits) >= 32'(thr_i[k]));
    end

    assign pat_n = (care_i != '0) && ((act & care_i) == (pat_i & care_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            maj_o <= '0;
            pat_o <= 1'b0;
        end else begin
            maj_o <= maj_n;
            pat_o <= pat_n;
        end
    end

endmodule

// File: rtl/mlu_sat_cnt.sv
module mlu_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            q_o <= '0;
        end else if (inc_i && q_o != '1) begin
            q_o <= q_o + W'(1);
        end
    end

endmodule

// File: rtl/mlu_top.sv
module mlu_top
    import mlu_pkg::*;
#(
    parameter int N_IN  = 32,
    parameter int N_GRP = 2,
    parameter int CNT_W = 32,
    localparam int N_CNT = N_IN + N_GRP * OUT_PER_GRP,
    localparam int SEL_W = $clog2(N_CNT)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_IN-1:0]        din,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [CFG_W-1:0]       cfg_wdata,
    input  logic [SEL_W-1:0]       cnt_sel,
    output logic [CNT_W-1:0]       cnt_value,
    output logic [N_GRP*N_THR-1:0] maj_out,
    output logic [N_GRP-1:0]       pat_out
);

    localparam int N_OUT = N_GRP * OUT_PER_GRP;

    // Configuration state
    tcfg_t                                  tcfg [N_IN];
    logic [N_GRP-1:0][N_IN-1:0]             mask_r;
    logic [N_GRP-1:0][N_IN-1:0]             care_r;
    logic [N_GRP-1:0][N_IN-1:0]             pat_r;
    logic [N_GRP-1:0][N_THR-1:0][THR_W-1:0] thr_r;

    logic              clr_w;
    logic [N_IN-1:0]   din_d;
    logic [N_IN-1:0]   edge_v;
    logic [N_IN-1:0]   gate_vec;
    logic [N_OUT-1:0]  out_all;
    logic [N_OUT-1:0]  out_d;
    logic [N_CNT-1:0]  inc_v;
    logic [CNT_W-1:0]  cnt_q [N_CNT];

    assign clr_w = cfg_we && (cfg_addr == CLR_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_IN; i++) tcfg[i] <= '0;
            mask_r <= '0;
            care_r <= '0;
            pat_r  <= '0;
            thr_r  <= '1;
        end else if (cfg_we) begin
            for (int i = 0; i < N_IN; i++) begin
                if (cfg_addr == ADDR_W'(i)) tcfg[i] <= tcfg_t'(cfg_wdata[2*TICK_W-1:0]);
            end
            for (int g = 0; g < N_GRP; g++) begin
                if (cfg_addr == grp_addr(g, GR_MASK)) mask_r[g] <= cfg_wdata[N_IN-1:0];
                if (cfg_addr == grp_addr(g, GR_CARE)) care_r[g] <= cfg_wdata[N_IN-1:0];
                if (cfg_addr == grp_addr(g, GR_PAT))  pat_r[g]  <= cfg_wdata[N_IN-1:0];
                if (cfg_addr == grp_addr(g, GR_THR)) begin
                    for (int k = 0; k < N_THR; k++) thr_r[g][k] <= cfg_wdata[8*k +: THR_W];
                end
            end
        end
    end

    // Edge detector; the history register also samples during reset so that
    // a level already high at release is not taken as an edge.
    always_ff @(posedge clk) begin
        din_d <= din;
    end
    assign edge_v = din & ~din_d;

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        mlu_ddg u_ddg (
            .clk    (clk),
            .rst    (rst),
            .trig_i (edge_v[i]),
            .cfg_i  (tcfg[i]),
            .gate_o (gate_vec[i])
        );
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        mlu_group #(.N_IN(N_IN)) u_grp (
            .clk    (clk),
            .rst    (rst),
            .gate_i (gate_vec),
            .mask_i (mask_r[g]),
            .care_i (care_r[g]),
            .pat_i  (pat_r[g]),
            .thr_i  (thr_r[g]),
            .maj_o  (maj_out[g*N_THR +: N_THR]),
            .pat_o  (pat_out[g])
        );
        assign out_all[g*OUT_PER_GRP +: OUT_PER_GRP] = {pat_out[g], maj_out[g*N_THR +: N_THR]};
    end

    always_ff @(posedge clk) begin
        if (rst) out_d <= '0;
        else     out_d <= out_all;
    end

    assign inc_v = {out_all & ~out_d, edge_v};

    for (genvar c = 0; c < N_CNT; c++) begin : g_cnt
        mlu_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr_i (clr_w),
            .inc_i (inc_v[c]),
            .q_o   (cnt_q[c])
        );
    end

    always_comb begin
        cnt_value = '0;
        for (int c = 0; c < N_CNT; c++) begin
            if (cnt_sel == SEL_W'(c)) cnt_value = cnt_q[c];
        end
    end

endmodule

// File: rtl/mlu_checker.sv
module mlu_checker
    import mlu_pkg::*;
#(
    parameter int N_IN  = 32,
    parameter int N_GRP = 2,
    parameter int CNT_W = 32,
    parameter int SEL_W = 6
) (
    input logic                                   clk,
    input logic                                   rst,
    input logic [N_IN-1:0]                        din,
    input logic                                   cfg_we,
    input logic [ADDR_W-1:0]                      cfg_addr,
    input logic [SEL_W-1:0]                       cnt_sel,
    input logic [CNT_W-1:0]                       cnt_value,
    input logic [N_GRP*N_THR-1:0]                 maj_out,
    input logic [N_GRP-1:0]                       pat_out,
    input logic [N_IN-1:0]                        gate_vec,
    input logic [N_GRP-1:0][N_IN-1:0]             mask_r,
    input logic [N_GRP-1:0][N_IN-1:0]             care_r,
    input logic [N_GRP-1:0][N_THR-1:0][THR_W-1:0] thr_r
);

    localparam int IW = $clog2(N_IN);

    logic          clr_seen;
    logic [IW-1:0] in_idx;

    assign clr_seen = cfg_we && (cfg_addr == CLR_ADDR);
    assign in_idx   = cnt_sel[IW-1:0];

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp_chk
        for (genvar k = 0; k < N_THR; k++) begin : g_thr_chk
            // R5, R6
            p_quiet_group_r6: assert property (@(posedge clk) disable iff (rst)
                (((gate_vec & mask_r[g]) == '0) && (thr_r[g][k] != '0))
                |=> !maj_out[g*N_THR + k]);
        end
        // R7
        p_no_care_no_match_r7: assert property (@(posedge clk) disable iff (rst)
            (care_r[g] == '0) |=> !pat_out[g]);
    end

    // R8
    p_no_edge_no_count_r8: assert property (@(posedge clk) disable iff (rst)
        (!clr_seen && (32'(cnt_sel) < N_IN) && !$rose(din[in_idx]))
        |=> ((cnt_sel != $past(cnt_sel)) || (cnt_value == $past(cnt_value))));

    // R9
    p_sat_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ((cnt_value == '1) && !clr_seen)
        |=> ((cnt_sel != $past(cnt_sel)) || (cnt_value == '1)));

    // R10
    p_clear_zero_r10: assert property (@(posedge clk) disable iff (rst)
        clr_seen |=> (cnt_value == '0));

endmodule

bind mlu_top mlu_checker #(
    .N_IN  (N_IN),
    .N_GRP (N_GRP),
    .CNT_W (CNT_W),
    .SEL_W (SEL_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cnt_sel   (cnt_sel),
    .cnt_value (cnt_value),
    .maj_out   (maj_out),
    .pat_out   (pat_out),
    .gate_vec  (gate_vec),
    .mask_r    (mask_r),
    .care_r    (care_r),
    .thr_r     (thr_r)
);

// File: tb/mlu_top_tb_top.sv
module mlu_top_tb_top;

    localparam int N_IN  = 32;
    localparam int N_GRP = 2;
    localparam int CNT_W = 8;
    localparam int SEL_W = 6;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [N_IN-1:0]        din = '0;
    logic                   cfg_we = 1'b0;
    logic [6:0]             cfg_addr = '0;
    logic [31:0]            cfg_wdata = '0;
    logic [SEL_W-1:0]       cnt_sel = '0;
    logic [CNT_W-1:0]       cnt_value;
    logic [N_GRP*3-1:0]     maj_out;
    logic [N_GRP-1:0]       pat_out;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    mlu_top #(.N_IN(N_IN), .N_GRP(N_GRP), .CNT_W(CNT_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cnt_sel   (cnt_sel),
        .cnt_value (cnt_value),
        .maj_out   (maj_out),
        .pat_out   (pat_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int sel, output logic [31:0] v);
        cnt_sel = SEL_W'(sel);
        #1;
        v = 32'(cnt_value);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Raise the given inputs for one cycle; returns at the sample after E1.
    task automatic pulse(input logic [N_IN-1:0] bits);
        @(negedge clk); din = din | bits;
        @(negedge clk); din = din & ~bits;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 maj_out", 32'(maj_out), 0);
        chk("R1 pat_out", 32'(pat_out), 0);
        rd(0, v);  chk("R1 input counter", v, 0);
        rd(32, v); chk("R1 output counter", v, 0);
    endtask

    task automatic t_threshold();
        for (int i = 0; i < 4; i++) wr(7'(i), 32'h0600);
        wr(7'd64, 32'hF);
        wr(7'd67, 32'h0003_0201);
        pulse(32'h1);  chk("R6 one hit",    32'(maj_out), 32'b000_001); idle(12);
        pulse(32'h3);  chk("R6 two hits",   32'(maj_out), 32'b000_011); idle(12);
        pulse(32'h7);  chk("R6 three hits", 32'(maj_out), 32'b000_111); idle(12);
        pulse(32'hF);  chk("R6 four hits",  32'(maj_out), 32'b000_111); idle(12);
    endtask

    task automatic t_timing();
        wr(7'd5, 32'h0403);                 // d=3, w=4
        wr(7'd68, 32'h20);
        wr(7'd71, 32'h003F_3F01);
        @(negedge clk); din[5] = 1'b1;
        for (int k = 0; k <= 9; k++) begin
            @(negedge clk);
            if (k == 0) din[5] = 1'b0;
            chk($sformatf("R3 delay/width k=%0d", k), 32'(maj_out[3]), 32'((k >= 4) && (k <= 7)));
        end
        wr(7'd5, 32'h0000);                 // width zero
        @(negedge clk); din[5] = 1'b1;
        for (int k = 0; k <= 4; k++) begin
            @(negedge clk);
            if (k == 0) din[5] = 1'b0;
            if (k == 2) chk("R3 width zero", 32'(maj_out[3]), 0);
        end
    endtask

    task automatic t_retrigger();
        wr(7'd6, 32'h0400);                 // d=0, w=4
        wr(7'd68, 32'h40);
        @(negedge clk); din[6] = 1'b1;
        @(negedge clk); din[6] = 1'b0;      // k=0
        @(negedge clk); din[6] = 1'b1;      // k=1, second edge at E2
        for (int k = 2; k <= 14; k++) begin
            @(negedge clk);
            if (k == 6)  chk("R4 gate restarted", 32'(maj_out[3]), 1);
            if (k == 7)  chk("R4 gate end after restart", 32'(maj_out[3]), 0);
            if (k == 14) chk("R2 held level no retrigger", 32'(maj_out[3]), 0);
        end
        din[6] = 1'b0;
        idle(4);
    endtask

    task automatic t_mask();
        logic [31:0] v0, v1;
        wr(7'd10, 32'h0600);
        rd(10, v0);
        @(negedge clk); din[10] = 1'b1;
        @(negedge clk); din[10] = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (k == 1 || k == 3) chk("R5 unmasked input ignored", 32'(maj_out), 0);
        end
        rd(10, v1);
        chk("R8 input edge counted", v1, v0 + 1);
        idle(8);
    endtask

    task automatic t_pattern();
        for (int i = 8; i < 12; i++) wr(7'(i), 32'h0600);
        wr(7'd71, 32'h003F_3F3F);
        wr(7'd68, 32'hF00);
        wr(7'd69, 32'hF00);
        wr(7'd70, 32'h500);
        pulse(32'h500); chk("R7 pattern match", 32'(pat_out[1]), 1);
        chk("R7 empty care mask", 32'(pat_out[0]), 0); idle(12);
        pulse(32'h700); chk("R7 extra bit mismatch", 32'(pat_out[1]), 0);
        idle(2);        chk("R7 mismatch held", 32'(pat_out[1]), 0); idle(12);
        pulse(32'h100); chk("R7 missing bit mismatch", 32'(pat_out[1]), 0); idle(12);
    endtask

    task automatic t_counters();
        logic [31:0] v;
        wr(7'd127, 32'h0);
        rd(0, v); chk("R10 cleared input counter", v, 0);
        for (int n = 0; n < 3; n++) begin pulse(32'h1); idle(12); end
        rd(0, v);  chk("R8 input 0 edges", v, 3);
        rd(32, v); chk("R8 group0 out0 rises", v, 3);
        rd(33, v); chk("R8 group0 out1 quiet", v, 0);
        for (int n = 0; n < 300; n++) begin
            @(negedge clk); din[1] = 1'b1;
            @(negedge clk); din[1] = 1'b0;
        end
        idle(2);
        rd(1, v); chk("R9 saturated", v, 255);
        wr(7'd127, 32'h0);
        rd(1, v);  chk("R10 clear saturated", v, 0);
        rd(32, v); chk("R10 clear output counter", v, 0);
    endtask

    initial begin
        #(20 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_threshold();
        t_timing();
        t_retrigger();
        t_mask();
        t_pattern();
        t_counters();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule